// File: doc/BRIEF.md
# Supply-Sequencing Logic Cell

This block is one cell of a nine-cell programmable logic array that decides when power rails are sequenced. The cell takes three groups of inputs. The first group is the outputs of the eight sibling cells, fed back. The second is seven supply-fault flags. The third is four general-purpose logic inputs. The cell has two product terms, called A and B. Each term can invert any input on its own and can drop any input on its own. A term is the AND of the inputs it keeps, after inversion. The cell output is the OR of the two terms, and it feeds a downstream delay stage.

Configuration lives in ten byte-wide registers. Reset clears them, so no input is inverted and none is dropped. A register-write port can rewrite them at run time. The output is combinational from the inputs and the stored configuration. A register write therefore becomes visible just after the clock edge that captures it.

Top module: `mc_sequencer_cell`

## Requirements
- R1: Reset clears every configuration register to zero. Each term is then the AND of all 19 inputs, so `cell_out` is 1 only when all 19 inputs are 1.
- R2: When a polarity bit is 1, the matching input is inverted before it enters that term.
- R3: When an ignore bit is 1, the matching input has no effect on that term.
- R4: A term whose 19 ignore bits are all 1 evaluates to 0.
- R5: `cell_out` is the OR of term A and term B. When both terms have every input ignored, `cell_out` is 0.
- R6: Terms A and B keep separate registers. The address map is: 0 = A feedback polarity, 1 = A feedback ignore, 2 = A fault polarity, 3 = A fault ignore, 4 = B feedback polarity, 5 = B feedback ignore, 6 = B fault polarity, 7 = B fault ignore.
- R7: Address 8 holds the general-purpose polarity bits and address 9 holds the general-purpose ignore bits. In both registers, bit 4+i belongs to `gpi_in[i]` for term A, and bit i belongs to `gpi_in[i]` for term B.
- R8: In the feedback registers, bit i controls `fb_in[i]`. In the fault registers, bit i controls `flt_in[i]` for i = 0 to 6, and bit 7 has no effect.
- R9: A write with `wr_en` high is captured at a rising edge and is in force from just after that edge. Before that edge the output still follows the old configuration.
- R10: No configuration changes when `wr_en` is low, or when `wr_en` is high and the address is 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| fb_in | input | 8 | Outputs of the eight sibling cells |
| flt_in | input | 7 | Supply-fault flags |
| gpi_in | input | 4 | General-purpose logic inputs |
| cell_out | output | 1 | Cell output (term A OR term B) |

## Verification
Assertions check on every cycle that:
- reset clears the configuration;
- a write lands in the addressed field on the next cycle, including the split of the general-purpose registers between A and B;
- an idle port leaves the configuration unchanged;
- a term whose inputs are all ignored stays low;
- a term with nothing ignored is high exactly when every input differs from its polarity bit.

Only the bench scenarios can show the rest:
- how single bits in each register line up with the input pins;
- that bit 7 of a fault register has no effect;
- that unmapped addresses change nothing;
- that the output keeps the old configuration up to the capturing edge.

The bench compares `cell_out` with a behavioural model before and after every clock edge to check these.

// File: rtl/mc_cfg_pkg.sv
package mc_cfg_pkg;
    localparam int NUM_CELLS = 9;
    localparam int FB_W      = NUM_CELLS - 1;
    localparam int FLT_W     = 7;
    localparam int GPI_W     = 4;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int TERM_W    = FB_W + FLT_W + GPI_W;
    localparam int NUM_TERMS = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_A_FB_POL  = 4'd0,
        REG_A_FB_IGN  = 4'd1,
        REG_A_FLT_POL = 4'd2,
        REG_A_FLT_IGN = 4'd3,
        REG_B_FB_POL  = 4'd4,
        REG_B_FB_IGN  = 4'd5,
        REG_B_FLT_POL = 4'd6,
        REG_B_FLT_IGN = 4'd7,
        REG_GPI_POL   = 4'd8,
        REG_GPI_IGN   = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic [FB_W-1:0]  fb_pol;
        logic [FB_W-1:0]  fb_ign;
        logic [FLT_W-1:0] flt_pol;
        logic [FLT_W-1:0] flt_ign;
        logic [GPI_W-1:0] gpi_pol;
        logic [GPI_W-1:0] gpi_ign;
    } term_cfg_t;
endpackage

// File: rtl/mc_cfg_regs.sv
module mc_cfg_regs
    import mc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output term_cfg_t         cfg_a,
    output term_cfg_t         cfg_b
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a <= '0;
            cfg_b <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_A_FB_POL:  cfg_a.fb_pol  <= wr_data[FB_W-1:0];
                REG_A_FB_IGN:  cfg_a.fb_ign  <= wr_data[FB_W-1:0];
                REG_A_FLT_POL: cfg_a.flt_pol <= wr_data[FLT_W-1:0];
                REG_A_FLT_IGN: cfg_a.flt_ign <= wr_data[FLT_W-1:0];
                REG_B_FB_POL:  cfg_b.fb_pol  <= wr_data[FB_W-1:0];
                REG_B_FB_IGN:  cfg_b.fb_ign  <= wr_data[FB_W-1:0];
                REG_B_FLT_POL: cfg_b.flt_pol <= wr_data[FLT_W-1:0];
                REG_B_FLT_IGN: cfg_b.flt_ign <= wr_data[FLT_W-1:0];
                REG_GPI_POL: begin
                    cfg_a.gpi_pol <= wr_data[DATA_W-1 -: GPI_W];
                    cfg_b.gpi_pol <= wr_data[GPI_W-1:0];
                end
                REG_GPI_IGN: begin
                    cfg_a.gpi_ign <= wr_data[DATA_W-1 -: GPI_W];
                    cfg_b.gpi_ign <= wr_data[GPI_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // R1: reset leaves every field cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_a == '0) && (cfg_b == '0));

    // R9: a write reaches the addressed field on the next cycle
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_B_FLT_POL) |=> cfg_b.flt_pol == $past(wr_data[FLT_W-1:0]));

    // R7: general-purpose register splits high nibble to A, low nibble to B
    assert_gpi_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_GPI_IGN) |=>
            (cfg_a.gpi_ign == $past(wr_data[DATA_W-1 -: GPI_W])) &&
            (cfg_b.gpi_ign == $past(wr_data[GPI_W-1:0])));

    // R10: idle port keeps the configuration
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(cfg_a) && $stable(cfg_b));
endmodule

// File: rtl/mc_product_term.sv
module mc_product_term #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_vec,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ign,
    output logic         term
);
    logic [W-1:0] adjusted;
    logic         any_kept;

    always_comb begin
        adjusted = (in_vec ^ pol) | ign;
        any_kept = |(~ign);
        term     = any_kept & (&adjusted);
    end

    // R4: a fully ignored term stays low
    assert_all_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&ign) |-> !term);

    // R2: with nothing ignored, inputs opposite to every polarity bit raise the term
    assert_match_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ign == '0) && (in_vec == ~pol)) |-> term);

    // R3: with nothing ignored, any other input pattern leaves the term low
    assert_mismatch_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ign == '0) && (in_vec != ~pol)) |-> !term);
endmodule

// File: rtl/mc_sequencer_cell.sv
module mc_sequencer_cell
    import mc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FB_W-1:0]   fb_in,
    input  logic [FLT_W-1:0]  flt_in,
    input  logic [GPI_W-1:0]  gpi_in,
    output logic              cell_out
);
    term_cfg_t             cfg_a;
    term_cfg_t             cfg_b;
    term_cfg_t             cfg_sel [NUM_TERMS];
    logic [NUM_TERMS-1:0]  terms;
    logic [TERM_W-1:0]     in_vec;

    mc_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_a   (cfg_a),
        .cfg_b   (cfg_b)
    );

    assign cfg_sel[0] = cfg_a;
    assign cfg_sel[1] = cfg_b;
    assign in_vec     = {gpi_in, flt_in, fb_in};

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        mc_product_term #(.W(TERM_W)) u_term (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vec (in_vec),
            .pol    ({cfg_sel[t].gpi_pol, cfg_sel[t].flt_pol, cfg_sel[t].fb_pol}),
            .ign    ({cfg_sel[t].gpi_ign, cfg_sel[t].flt_ign, cfg_sel[t].fb_ign}),
            .term   (terms[t])
        );
    end

    assign cell_out = |terms;

    // R5: when both terms ignore every input the cell output is low
    assert_both_masked_out_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cfg_a.fb_ign) && (&cfg_a.flt_ign) && (&cfg_a.gpi_ign) &&
         (&cfg_b.fb_ign) && (&cfg_b.flt_ign) && (&cfg_b.gpi_ign)) |-> !cell_out);
endmodule

// File: tb/mc_sequencer_cell_bench.sv
module mc_sequencer_cell_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] fb_in;
    logic [6:0] flt_in;
    logic [3:0] gpi_in;
    logic       cell_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [16];

    always #5 clk = ~clk;

    mc_sequencer_cell u_mc_sequencer_cell (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fb_in(fb_in), .flt_in(flt_in), .gpi_in(gpi_in),
        .cell_out(cell_out)
    );

    // Behavioural model of one term from the register map in the requirements
    function automatic logic mdl_term(int fn, logic [7:0] fb, logic [6:0] flt, logic [3:0] gpi);
        int   base;
        logic any_kept;
        logic all_true;
        logic p;
        logic g;
        base     = fn * 4;
        any_kept = 1'b0;
        all_true = 1'b1;
        for (int i = 0; i < 8; i++) begin
            p = mdl[base][i];
            g = mdl[base + 1][i];
            if (!g) begin
                any_kept = 1'b1;
                if ((fb[i] ^ p) == 1'b0) all_true = 1'b0;
            end
        end
        for (int i = 0; i < 7; i++) begin
            p = mdl[base + 2][i];
            g = mdl[base + 3][i];
            if (!g) begin
                any_kept = 1'b1;
                if ((flt[i] ^ p) == 1'b0) all_true = 1'b0;
            end
        end
        for (int i = 0; i < 4; i++) begin
            p = mdl[8][fn == 0 ? i + 4 : i];
            g = mdl[9][fn == 0 ? i + 4 : i];
            if (!g) begin
                any_kept = 1'b1;
                if ((gpi[i] ^ p) == 1'b0) all_true = 1'b0;
            end
        end
        return any_kept && all_true;
    endfunction

    function automatic logic mdl_out(logic [7:0] fb, logic [6:0] flt, logic [3:0] gpi);
        return mdl_term(0, fb, flt, gpi) | mdl_term(1, fb, flt, gpi);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cell_out=%b expected %b", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; checks before and after the next rising edge
    task automatic step(logic we, logic [3:0] a, logic [7:0] d,
                        logic [7:0] fb, logic [6:0] flt, logic [3:0] gpi, string tag);
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        fb_in   = fb;
        flt_in  = flt;
        gpi_in  = gpi;
        #1;
        check({tag, " (R9 before edge)"}, cell_out, mdl_out(fb, flt, gpi));
        @(posedge clk);
        if (we && rst_n && a < 4'd10) mdl[a] = d;
        @(negedge clk);
        check(tag, cell_out, mdl_out(fb, flt, gpi));
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: run still active, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        fb_in = 8'hFF; flt_in = 7'h7F; gpi_in = 4'hF;
        repeat (3) @(negedge clk);
        #1 check("R1 reset all ones", cell_out, 1'b1);
        gpi_in = 4'h7;
        #1 check("R1 reset one low input", cell_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 0, 8'hFF, 7'h7F, 4'hF, "R1 all ones");
        check("R1 literal all ones", cell_out, 1'b1);
        step(0, 0, 0, 8'hFE, 7'h7F, 4'hF, "R1 fb0 low");
        check("R1 literal fb0 low", cell_out, 1'b0);
        step(0, 0, 0, 8'hFF, 7'h3F, 4'hF, "R1 flt6 low");

        step(1, 4'd1, 8'h04, 8'hFB, 7'h7F, 4'hF, "R3 ignore fb2 in A");
        check("R3 literal fb2 ignored", cell_out, 1'b1);
        step(0, 0, 0, 8'hF3, 7'h7F, 4'hF, "R8 fb3 still counted");
        check("R8 literal fb3 low", cell_out, 1'b0);

        step(1, 4'd2, 8'h08, 8'hFB, 7'h77, 4'hF, "R2 invert flt3 in A");
        check("R2 literal inverted flt3", cell_out, 1'b1);
        step(0, 0, 0, 8'hFB, 7'h7F, 4'hF, "R2 flt3 high now fails");
        check("R2 literal flt3 high", cell_out, 1'b0);

        step(1, 4'd4, 8'hFF, 8'h00, 7'h7F, 4'hF, "R6 B inverts all fb");
        check("R5 literal B alone drives output", cell_out, 1'b1);
        step(0, 0, 0, 8'hFB, 7'h77, 4'hF, "R5 A alone drives output");
        check("R5 literal A alone", cell_out, 1'b1);

        step(1, 4'd8, 8'h01, 8'h00, 7'h7F, 4'hE, "R7 B gpi0 inverted");
        check("R7 literal B gpi0 low", cell_out, 1'b1);
        step(0, 0, 0, 8'h00, 7'h7F, 4'hF, "R7 B gpi0 high fails");
        check("R7 literal B gpi0 high", cell_out, 1'b0);
        step(1, 4'd8, 8'h10, 8'hFB, 7'h77, 4'hE, "R7 A gpi0 inverted via bit4");

        step(1, 4'd3, 8'h80, 8'hFB, 7'h77, 4'hE, "R8 fault bit7 no effect");
        step(1, 4'd1, 8'hFF, 8'hFF, 7'h7F, 4'hF, "R4 A fb all ignored");
        step(1, 4'd3, 8'h7F, 8'hFF, 7'h7F, 4'hF, "R4 A flt all ignored");
        step(1, 4'd9, 8'hF0, 8'hFF, 7'h7F, 4'hF, "R4 A fully ignored");
        step(1, 4'd5, 8'hFF, 8'hFF, 7'h7F, 4'hF, "R4 B fb ignored");
        step(1, 4'd7, 8'h7F, 8'hFF, 7'h7F, 4'hF, "R4 B flt ignored");
        step(1, 4'd9, 8'hFF, 8'hFF, 7'h7F, 4'hF, "R5 both fully ignored");
        check("R5 literal both ignored low", cell_out, 1'b0);

        step(0, 4'd9, 8'h00, 8'hFF, 7'h7F, 4'hF, "R10 strobe low ignored");
        check("R10 literal strobe low", cell_out, 1'b0);
        step(1, 4'd12, 8'h00, 8'hFF, 7'h7F, 4'hF, "R10 address 12 ignored");
        step(1, 4'd15, 8'h00, 8'hFF, 7'h7F, 4'hF, "R10 address 15 ignored");
        check("R10 literal unmapped", cell_out, 1'b0);
        step(1, 4'd9, 8'h00, 8'hFF, 7'h7F, 4'hF, "R9 gpi ignores cleared");

        for (int n = 0; n < 400; n++) begin
            step(($urandom % 3) == 0, 4'($urandom), 8'($urandom),
                 8'($urandom | $urandom | $urandom), 7'($urandom | $urandom | $urandom),
                 4'($urandom | $urandom), "R6 random traffic");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule